// File: doc/BRIEF.md
# PPS-Locked Gate Pulse Generator

This block runs in a single 240 MHz domain and produces one gate pulse for every rising edge of an asynchronous pulse-per-second input. The start of the pulse is placed a programmable number of whole clock periods after the detected edge (coarse delay). The high time of the pulse is also a whole number of clock periods, and it never falls below two periods, which keeps it above 5 ns. The pulse is driven on two outputs. One output goes on to a sub-period fine-delay stage. The other is a replica that bypasses that stage.

The 4-bit width and delay inputs are assumed to be synchronised already. They take effect only when an update strobe is seen. A strobe that arrives while a pulse is pending or active is held and applied once the generator is idle again, so a pulse in flight never changes shape.

The state machine has three states. `ST_IDLE` waits for an edge. `ST_WAIT` counts down the coarse delay. `ST_HIGH` counts down the pulse width. The transitions are:

- `ST_IDLE` goes to `ST_WAIT` on an edge when the delay is nonzero.
- `ST_IDLE` goes to `ST_HIGH` on an edge when the delay is zero.
- `ST_WAIT` goes to `ST_HIGH` when its count reaches zero.
- `ST_HIGH` goes to `ST_IDLE` when its count reaches zero.

Top module: `pps_gate_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, both outputs are low. Reset sets the working width to 2 and the working delay to 0.
- R2: Edge 0 is the first rising clock edge that samples `pps_in` high. The outputs become high after edge 2+D, where D is the working delay value (0 to 15).
- R3: With a working width value W of 2 or more, the outputs stay high for exactly W clock periods.
- R4: A width value of 0 or 1 is applied as 2 periods.
- R5: A `pps_in` rising edge that reaches the state machine while a pulse is pending or high is ignored, and it produces no extra pulse.
- R6: Holding `pps_in` high produces only one pulse. Only a low-to-high transition starts a pulse.
- R7: Changing `duty_in` or `delay_in` without a strobe has no effect on later pulses.
- R8: A strobe seen while a pulse is pending or high leaves that pulse unchanged. The next pulse uses the values that were captured with the strobe.
- R9: `gate_bypass_out` equals `gate_out` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 240 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| upd_stb | input | 1 | Strobe that captures `duty_in` and `delay_in` |
| duty_in | input | CNT_W | Requested pulse width in clock periods |
| delay_in | input | CNT_W | Requested coarse delay in clock periods |
| gate_out | output | 1 | Gate pulse sent to the fine-delay stage |
| gate_bypass_out | output | 1 | Replica gate pulse that bypasses fine delay |

## Verification
The bench builds the block with its defaults: a 4-bit count width, a two-period minimum width and a two-stage synchroniser. With these values every delay and width code (0 to 15) can be driven directly, including the clamped codes 0 and 1. The longest pulse, 2+15+15 cycles after the edge, is short enough that the bench can check each pulse cycle by cycle. The small count range also puts the in-flight cases within reach: a retriggering edge during the high phase, and an update strobe during the coarse wait.

// File: rtl/pps_gate_pkg.sv
`timescale 1ns/1ps
package pps_gate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HIGH = 2'd2
    } gate_state_e;
endpackage

// File: rtl/pps_edge_sync.sv
`timescale 1ns/1ps
module pps_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    // sync chain plus one history flop for edge detection
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/gate_cfg_regs.sv
`timescale 1ns/1ps
module gate_cfg_regs #(
    parameter int CNT_W     = 4,
    parameter int MIN_WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_stb,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0] delay_in,
    input  logic             idle,
    output logic [CNT_W-1:0] work_width,
    output logic [CNT_W-1:0] work_delay
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_WIDTH);

    logic [CNT_W-1:0] stage_width, stage_delay;
    logic             pend_q;

    function automatic logic [CNT_W-1:0] clamp_w(input logic [CNT_W-1:0] v);
        return (v < MIN_V) ? MIN_V : v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            work_width  <= MIN_V;
            work_delay  <= '0;
            stage_width <= MIN_V;
            stage_delay <= '0;
            pend_q      <= 1'b0;
        end else if (upd_stb && idle) begin
            work_width <= clamp_w(duty_in);
            work_delay <= delay_in;
            pend_q     <= 1'b0;
        end else if (upd_stb) begin
            // busy: park the request until the generator is idle
            stage_width <= clamp_w(duty_in);
            stage_delay <= delay_in;
            pend_q      <= 1'b1;
        end else if (pend_q && idle) begin
            work_width <= stage_width;
            work_delay <= stage_delay;
            pend_q     <= 1'b0;
        end
    end
endmodule

// File: rtl/gate_fsm.sv
`timescale 1ns/1ps
module gate_fsm
    import pps_gate_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_rise,
    input  logic [CNT_W-1:0] work_width,
    input  logic [CNT_W-1:0] work_delay,
    output logic             busy,
    output logic             gate_a,
    output logic             gate_b
);
    gate_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pps_rise) begin
                    if (work_delay == '0) begin
                        state_d = ST_HIGH;
                        cnt_d   = work_width - 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                        cnt_d   = work_delay - 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (cnt_q == '0) begin
                    state_d = ST_HIGH;
                    cnt_d   = work_width - 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HIGH: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs, one flop per destination
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_a <= 1'b0;
            gate_b <= 1'b0;
        end else begin
            gate_a <= (state_d == ST_HIGH);
            gate_b <= (state_d == ST_HIGH);
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/pps_gate_gen.sv
`timescale 1ns/1ps
module pps_gate_gen #(
    parameter int CNT_W       = 4,
    parameter int MIN_WIDTH   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_in,
    input  logic             upd_stb,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0] delay_in,
    output logic             gate_out,
    output logic             gate_bypass_out
);
    logic             pps_rise;
    logic             busy;
    logic [CNT_W-1:0] work_width, work_delay;

    pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pps_in), .rise_o(pps_rise)
    );

    gate_cfg_regs #(.CNT_W(CNT_W), .MIN_WIDTH(MIN_WIDTH)) u_cfg (
        .clk(clk), .rst(rst), .upd_stb(upd_stb),
        .duty_in(duty_in), .delay_in(delay_in), .idle(!busy),
        .work_width(work_width), .work_delay(work_delay)
    );

    gate_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .pps_rise(pps_rise),
        .work_width(work_width), .work_delay(work_delay),
        .busy(busy), .gate_a(gate_out), .gate_b(gate_bypass_out)
    );
endmodule

// File: rtl/pps_gate_checker.sv
`timescale 1ns/1ps
module pps_gate_checker #(
    parameter int CNT_W     = 4,
    parameter int MIN_WIDTH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             gate_out,
    input logic             gate_bypass_out,
    input logic             busy,
    input logic [CNT_W-1:0] work_width,
    input logic [CNT_W-1:0] work_delay
);
    localparam int MAX_RUN = (1 << CNT_W) - 1;
    logic [CNT_W:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)           run_q <= '0;
        else if (gate_out) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (!gate_out && !gate_bypass_out));

    p_run_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        run_q <= (CNT_W+1)'(MAX_RUN));

    p_min_width_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_out) |-> run_q >= (CNT_W+1)'(MIN_WIDTH));

    p_cfg_clamped_r4: assert property (@(posedge clk) disable iff (rst)
        work_width >= CNT_W'(MIN_WIDTH));

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(work_width) && $stable(work_delay)));

    p_replica_r9: assert property (@(posedge clk) disable iff (rst)
        gate_out == gate_bypass_out);
endmodule

bind pps_gate_gen pps_gate_checker #(.CNT_W(CNT_W), .MIN_WIDTH(MIN_WIDTH)) u_chk (
    .clk(clk), .rst(rst), .gate_out(gate_out), .gate_bypass_out(gate_bypass_out),
    .busy(busy), .work_width(work_width), .work_delay(work_delay)
);

// File: tb/pps_gate_gen_test.sv
`timescale 1ns/1ps
module pps_gate_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pps_in = 1'b0;
    logic       upd_stb = 1'b0;
    logic [3:0] duty_in = 4'd0;
    logic [3:0] delay_in = 4'd0;
    logic       gate_out, gate_bypass_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pps_gate_gen uut (
        .clk(clk), .rst(rst), .pps_in(pps_in), .upd_stb(upd_stb),
        .duty_in(duty_in), .delay_in(delay_in),
        .gate_out(gate_out), .gate_bypass_out(gate_bypass_out)
    );

    function automatic int eff_width(input int w);
        return (w < 2) ? 2 : w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int w, input int d);
        @(negedge clk);
        duty_in = 4'(w); delay_in = 4'(d); upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    // One pulse from a PPS rise; compares every cycle against the model.
    task automatic run_pulse(input string req, input int d, input int w,
                             input bit retrig, input bit mid_upd,
                             input int nw, input int nd);
        int ew, first_bad, act_at, exp_at, rep_bad;
        ew = eff_width(w);
        first_bad = -1; act_at = 0; exp_at = 0; rep_bad = 0;
        @(negedge clk);
        pps_in = 1'b1;
        for (int i = 0; i < 2 + d + ew + 10; i++) begin
            bit e;
            @(posedge clk);
            @(negedge clk);
            e = (i >= 2 + d) && (i < 2 + d + ew);
            if (first_bad < 0 && gate_out != e) begin
                first_bad = i; act_at = int'(gate_out); exp_at = int'(e);
            end
            if (gate_bypass_out != gate_out) rep_bad++;
            if (retrig && i == 2 + d + 1) pps_in = 1'b0;
            if (retrig && i == 2 + d + 3) pps_in = 1'b1;
            if (mid_upd && i == 3) begin
                duty_in = 4'(nw); delay_in = 4'(nd); upd_stb = 1'b1;
            end
            if (mid_upd && i == 4) upd_stb = 1'b0;
        end
        if (first_bad >= 0)
            $display("  mismatch in %s at cycle %0d (d=%0d w=%0d)", req, first_bad, d, w);
        check(req, act_at, exp_at);
        check("R9 replica", rep_bad, 0);
        pps_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int rw, rd;
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        check("R1 gate in reset", int'(gate_out), 0);
        check("R1 bypass in reset", int'(gate_bypass_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 gate after reset", int'(gate_out), 0);
        // reset defaults: delay 0, width 2
        run_pulse("R1 R2 default pulse", 0, 2, 0, 0, 0, 0);

        strobe(5, 3);
        run_pulse("R2 R3 d3 w5", 3, 5, 0, 0, 0, 0);
        strobe(15, 15);
        run_pulse("R2 R3 max d15 w15", 15, 15, 0, 0, 0, 0);
        strobe(0, 1);
        run_pulse("R4 width0 clamp", 1, 0, 0, 0, 0, 0);
        strobe(1, 0);
        run_pulse("R4 width1 clamp", 0, 1, 0, 0, 0, 0);
        strobe(10, 2);
        run_pulse("R5 R6 retrigger ignored", 2, 10, 1, 0, 0, 0);

        // R7: new inputs without a strobe
        @(negedge clk);
        duty_in = 4'd3; delay_in = 4'd9;
        run_pulse("R7 no strobe no change", 2, 10, 0, 0, 0, 0);

        // R8: strobe during the coarse wait
        strobe(4, 6);
        run_pulse("R8 in-flight pulse unchanged", 6, 4, 0, 1, 7, 1);
        run_pulse("R8 deferred values applied", 1, 7, 0, 0, 0, 0);

        for (int k = 0; k < 16; k++) begin
            rw = int'($urandom_range(0, 15));
            rd = int'($urandom_range(0, 15));
            strobe(rw, rd);
            run_pulse("R2 R3 R4 random", rd, rw, 0, 0, 0, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule